// File: doc/BRIEF.md
# Chained Two-Buffer DMA Channel

A single DMA channel moves 32-bit words between memory and a device, one address per memory handshake, in the direction that software picks. Software describes the active buffer with an address pair that runs from a moving pointer up to an end address, and a follow-on buffer with a second pair. A single-shot "update pending" flag decides what happens when the active buffer is used up. With the flag set, the follow-on pair is copied into the active pair and the transfer goes on without a gap. With the flag clear, the channel shuts itself down.

Every buffer boundary sets a complete flag that also drives the interrupt line. The completion handler reads where the finished buffer really ended, then either re-arms chaining in one command write or lets the channel stop. Bit 31 of the end addresses is a mode flag that the channel carries along but leaves out of every address comparison. A memory error response stops the channel, sets a bus-exception flag and still raises the interrupt.

Top module: `dma_chain_chan`

## Requirements
- R1: After the asynchronous reset, the status word reads 0, `irq_o` is low and `mem_req_o` is low.
- R2: Word index 0 takes a command on write: bit0 set-enable, bit1 set-update, bit2 clear-complete, bit3 reset, bit4 init-buffer (it has no flag effect of its own), bit5 set-read, bit6 set-write. A read of index 0 returns the status: bit0 enable, bit1 update-pending, bit2 complete, bit3 bus-exception, bit4 read-direction. The reset command bit clears enable, update-pending, complete and bus-exception.
- R3: The address registers sit at word indices 1 pointer, 2 end, 3 follow-on start, 4 follow-on end, 5 saved pointer, 6 saved end, 7 saved start, 8 saved stop. While the channel is idle, each one reads back exactly the value written to it.
- R4: While enable is set and bits 30:0 of the pointer differ from bits 30:0 of the end register, `mem_req_o` is high with `mem_addr_o` equal to the pointer, and the request stays stable until it is answered. Each acknowledge advances the pointer by 4.
- R5: In read direction the memory is read (`mem_we_o` low), and every acknowledged word is handed to the device on `dev_data_o` with a `dev_valid_o` pulse. In write direction `mem_we_o` is high and `mem_wdata_o` carries `dev_data_i`.
- R6: When the pointer reaches the end with update-pending set, the follow-on start and end are loaded into the pointer and end registers. The saved end takes the finished end and the saved pointer takes the new start. Complete is set, update-pending is cleared and enable stays set.
- R7: When the pointer reaches the end with update-pending clear, complete is set, enable is cleared and the pointer holds the end address.
- R8: Bit 31 of the end and follow-on end values is kept in the registers and in the saved end, and it is ignored when the pointer is compared against the end.
- R9: An error response sets bus-exception and complete and clears enable. The pointer does not advance, and the saved end holds the failing address with bit 31 of the end register.
- R10: `irq_o` follows complete and stays high until a clear-complete or reset command. A single command holding clear-complete, a direction bit and set-update clears the interrupt and re-arms chaining.
- R11: Word index 9 is an alias of the pointer register: a write there loads the pointer, and a read there returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_idx_i | input | 4 | Register word index for both read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from `reg_idx_i` |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (high) or read (low) |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data |
| mem_ack_i | input | 1 | Memory access done |
| mem_err_i | input | 1 | Memory access failed |
| dev_data_i | input | 32 | Word supplied by the device for memory writes |
| dev_data_o | output | 32 | Word delivered to the device on memory reads |
| dev_valid_o | output | 1 | `dev_data_o` is valid this cycle |
| irq_o | output | 1 | Completion interrupt |

## Verification
Several properties are checked on every cycle: an unanswered memory request holds its address, an acknowledge steps the pointer by exactly one word, a chaining event loads the follow-on start, a shutdown or error leaves enable cleared, the reset command clears the flags, and the interrupt never drops without a command write. Other behaviour can only be shown by the directed scenarios. These include the saved end address after a chain and after a fault, the masking of bit 31 at the end comparison, the data that reaches memory or the device, and a re-arm written inside the completion window that produces a second chain.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int IDX_W = 4;

  typedef enum logic [IDX_W-1:0] {
    IDX_CSR       = 4'd0,
    IDX_PTR       = 4'd1,
    IDX_END       = 4'd2,
    IDX_FSTART    = 4'd3,
    IDX_FEND      = 4'd4,
    IDX_SV_PTR    = 4'd5,
    IDX_SV_END    = 4'd6,
    IDX_SV_FSTART = 4'd7,
    IDX_SV_FEND   = 4'd8,
    IDX_PTR_INIT  = 4'd9
  } reg_idx_e;

  // command bit positions (write to IDX_CSR)
  localparam int C_SET_EN  = 0;
  localparam int C_SET_UPD = 1;
  localparam int C_CLR_CMP = 2;
  localparam int C_RST     = 3;
  localparam int C_SET_RD  = 5;
  localparam int C_SET_WR  = 6;

  typedef struct packed {
    logic set_wr;
    logic set_rd;
    logic rst;
    logic clr_cmp;
    logic set_upd;
    logic set_en;
  } cmd_t;

  typedef struct packed {
    logic rd_dir;
    logic bus_exc;
    logic complete;
    logic pending;
    logic enable;
  } status_t;

  function automatic cmd_t decode_cmd(input logic [31:0] w);
    cmd_t c;
    c.set_en  = w[C_SET_EN];
    c.set_upd = w[C_SET_UPD];
    c.clr_cmp = w[C_CLR_CMP];
    c.rst     = w[C_RST];
    c.set_rd  = w[C_SET_RD];
    c.set_wr  = w[C_SET_WR];
    return c;
  endfunction
endpackage

// File: rtl/dma_chain_flags.sv
module dma_chain_flags
  import dma_chain_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    cmd_wr_i,
  input  cmd_t    cmd_i,
  input  logic    chain_i,
  input  logic    stop_i,
  input  logic    err_i,
  output status_t status_o
);
  logic enable_q, pending_q, complete_q, bus_exc_q, rd_dir_q;

  // hardware events first, a command in the same cycle has the last word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q   <= 1'b0;
      pending_q  <= 1'b0;
      complete_q <= 1'b0;
      bus_exc_q  <= 1'b0;
      rd_dir_q   <= 1'b0;
    end else begin
      if (chain_i) begin
        complete_q <= 1'b1;
        pending_q  <= 1'b0;
      end
      if (stop_i) begin
        complete_q <= 1'b1;
        enable_q   <= 1'b0;
      end
      if (err_i) begin
        complete_q <= 1'b1;
        enable_q   <= 1'b0;
        bus_exc_q  <= 1'b1;
      end
      if (cmd_wr_i) begin
        if (cmd_i.rst) begin
          enable_q   <= 1'b0;
          pending_q  <= 1'b0;
          complete_q <= 1'b0;
          bus_exc_q  <= 1'b0;
        end
        if (cmd_i.set_en)  enable_q   <= 1'b1;
        if (cmd_i.set_upd) pending_q  <= 1'b1;
        if (cmd_i.clr_cmp) complete_q <= 1'b0;
        if (cmd_i.set_rd)  rd_dir_q   <= 1'b1;
        if (cmd_i.set_wr)  rd_dir_q   <= 1'b0;
      end
    end
  end

  assign status_o = '{rd_dir: rd_dir_q, bus_exc: bus_exc_q, complete: complete_q,
                      pending: pending_q, enable: enable_q};

  a_r7_stop_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !(cmd_wr_i && cmd_i.set_en) |=> !enable_q);

  a_r9_err_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i && !cmd_wr_i |=> bus_exc_q && complete_q && !enable_q);

  a_r2_rst_cmd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && cmd_i.rst && !cmd_i.set_en && !cmd_i.set_upd
    |=> !enable_q && !pending_q && !complete_q && !bus_exc_q);
endmodule

// File: rtl/dma_chain_addr.sv
module dma_chain_addr
  import dma_chain_pkg::*;
#(
  parameter int AW         = 32,
  parameter int STEP_BYTES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          step_i,
  input  logic          chain_i,
  input  logic          stop_i,
  input  logic          err_i,
  output logic [AW-1:0] ptr_o,
  output logic [AW-1:0] end_o,
  output logic [AW-1:0] fstart_o,
  output logic [AW-1:0] fend_o,
  output logic [AW-1:0] sv_ptr_o,
  output logic [AW-1:0] sv_end_o,
  output logic [AW-1:0] sv_fstart_o,
  output logic [AW-1:0] sv_fend_o,
  output logic          at_end_o
);
  localparam int MB = AW - 1;  // mode flag position in end values

  logic [AW-1:0] ptr_q, end_q, fstart_q, fend_q;
  logic [AW-1:0] sv_ptr_q, sv_end_q, sv_fstart_q, sv_fend_q;
  logic          wr_ptr;

  assign wr_ptr = wr_i && (idx_i == IDX_PTR || idx_i == IDX_PTR_INIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0; end_q <= '0; fstart_q <= '0; fend_q <= '0;
      sv_ptr_q <= '0; sv_end_q <= '0; sv_fstart_q <= '0; sv_fend_q <= '0;
    end else begin
      if (wr_ptr) ptr_q <= wdata_i;
      if (wr_i) begin
        case (reg_idx_e'(idx_i))
          IDX_END:       end_q       <= wdata_i;
          IDX_FSTART:    fstart_q    <= wdata_i;
          IDX_FEND:      fend_q      <= wdata_i;
          IDX_SV_PTR:    sv_ptr_q    <= wdata_i;
          IDX_SV_END:    sv_end_q    <= wdata_i;
          IDX_SV_FSTART: sv_fstart_q <= wdata_i;
          IDX_SV_FEND:   sv_fend_q   <= wdata_i;
          default: ;
        endcase
      end
      // hardware updates override a same-cycle software write
      if (step_i) ptr_q <= ptr_q + AW'(STEP_BYTES);
      if (chain_i) begin
        ptr_q    <= fstart_q;
        end_q    <= fend_q;
        sv_ptr_q <= fstart_q;
        sv_end_q <= end_q;
      end
      if (stop_i) sv_end_q <= end_q;
      if (err_i)  sv_end_q <= {end_q[MB], ptr_q[MB-1:0]};
    end
  end

  assign at_end_o    = (ptr_q[MB-1:0] == end_q[MB-1:0]);
  assign ptr_o       = ptr_q;
  assign end_o       = end_q;
  assign fstart_o    = fstart_q;
  assign fend_o      = fend_q;
  assign sv_ptr_o    = sv_ptr_q;
  assign sv_end_o    = sv_end_q;
  assign sv_fstart_o = sv_fstart_q;
  assign sv_fend_o   = sv_fend_q;

  a_r4_step_one_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !wr_ptr && !chain_i |=> ptr_q == $past(ptr_q) + AW'(STEP_BYTES));

  a_r6_chain_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_i |=> ptr_q == $past(fstart_q) && sv_end_q == $past(end_q));
endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
  import dma_chain_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int STEP_BYTES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [IDX_W-1:0] reg_idx_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic [DW-1:0]    mem_rdata_i,
  input  logic             mem_ack_i,
  input  logic             mem_err_i,
  input  logic [DW-1:0]    dev_data_i,
  output logic [DW-1:0]    dev_data_o,
  output logic             dev_valid_o,
  output logic             irq_o
);
  localparam int SW = $bits(status_t);

  status_t       st;
  cmd_t          cmd;
  logic          csr_wr, boundary, chain_evt, stop_evt, err_evt, step_evt, at_end;
  logic [AW-1:0] ptr, lim, fstart, fend, sv_ptr, sv_end, sv_fstart, sv_fend;

  assign csr_wr = reg_wr_i && (reg_idx_i == IDX_CSR);
  assign cmd    = decode_cmd(reg_wdata_i);

  assign mem_req_o  = st.enable && !at_end;
  assign boundary   = st.enable && at_end;
  assign chain_evt  = boundary && st.pending;
  assign stop_evt   = boundary && !st.pending;
  assign err_evt    = mem_req_o && mem_err_i;
  assign step_evt   = mem_req_o && mem_ack_i && !mem_err_i;

  dma_chain_flags u_flags (
    .clk_i, .rst_ni,
    .cmd_wr_i (csr_wr),
    .cmd_i    (cmd),
    .chain_i  (chain_evt),
    .stop_i   (stop_evt),
    .err_i    (err_evt),
    .status_o (st)
  );

  dma_chain_addr #(.AW(AW), .STEP_BYTES(STEP_BYTES)) u_addr (
    .clk_i, .rst_ni,
    .wr_i        (reg_wr_i),
    .idx_i       (reg_idx_i),
    .wdata_i     (reg_wdata_i[AW-1:0]),
    .step_i      (step_evt),
    .chain_i     (chain_evt),
    .stop_i      (stop_evt),
    .err_i       (err_evt),
    .ptr_o       (ptr),
    .end_o       (lim),
    .fstart_o    (fstart),
    .fend_o      (fend),
    .sv_ptr_o    (sv_ptr),
    .sv_end_o    (sv_end),
    .sv_fstart_o (sv_fstart),
    .sv_fend_o   (sv_fend),
    .at_end_o    (at_end)
  );

  assign mem_we_o    = !st.rd_dir;
  assign mem_addr_o  = ptr;
  assign mem_wdata_o = dev_data_i;
  assign dev_data_o  = mem_rdata_i;
  assign dev_valid_o = step_evt && st.rd_dir;
  assign irq_o       = st.complete;

  always_comb begin
    case (reg_idx_e'(reg_idx_i))
      IDX_CSR:                reg_rdata_o = 32'(st);
      IDX_PTR, IDX_PTR_INIT:  reg_rdata_o = 32'(ptr);
      IDX_END:                reg_rdata_o = 32'(lim);
      IDX_FSTART:             reg_rdata_o = 32'(fstart);
      IDX_FEND:               reg_rdata_o = 32'(fend);
      IDX_SV_PTR:             reg_rdata_o = 32'(sv_ptr);
      IDX_SV_END:             reg_rdata_o = 32'(sv_end);
      IDX_SV_FSTART:          reg_rdata_o = 32'(sv_fstart);
      IDX_SV_FEND:            reg_rdata_o = 32'(sv_fend);
      default:                reg_rdata_o = '0;
    endcase
  end

  initial assert (SW <= 32);

  a_r4_req_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i && !mem_err_i && !reg_wr_i
    |=> mem_req_o && $stable(mem_addr_o));

  a_r10_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !csr_wr |=> irq_o);

  a_r9_err_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt && !reg_wr_i |=> !mem_req_o && irq_o);
endmodule

// File: tb/sim_dma_chain_chan.sv
module sim_dma_chain_chan;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [3:0]  reg_idx_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mem_req_o, mem_we_o, dev_valid_o, irq_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i, dev_data_i, dev_data_o;
  logic        mem_ack_i = 1'b0, mem_err_i = 1'b0;

  int n_checks = 0, n_errors = 0;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;
  logic [31:0] mem [256];
  int          n_wr = 0, n_push = 0;
  logic [31:0] last_push = '0;

  always #10 clk = ~clk;  // 50 MHz

  dma_chain_chan u0 (
    .clk_i(clk), .rst_ni, .reg_wr_i, .reg_idx_i, .reg_wdata_i, .reg_rdata_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i,
    .mem_ack_i, .mem_err_i, .dev_data_i, .dev_data_o, .dev_valid_o, .irq_o
  );

  assign mem_rdata_i = 32'h5A00_0000 | mem_addr_o;
  assign dev_data_i  = 32'hD0D0_0000 | {16'h0, mem_addr_o[15:0]};

  // memory responder, driven away from the active edge
  always @(negedge clk) begin
    mem_err_i = mem_req_o && err_en && (mem_addr_o == err_addr);
    mem_ack_i = mem_req_o && !mem_err_i;
  end

  always @(posedge clk) begin
    if (mem_req_o && mem_ack_i && mem_we_o) begin
      mem[mem_addr_o[9:2]] <= mem_wdata_o;
      n_wr <= n_wr + 1;
    end
    if (dev_valid_o) begin
      n_push    <= n_push + 1;
      last_push <= dev_data_o;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_idx_i = idx; reg_wdata_i = d;
    @(posedge clk); #1;
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] d);
    @(negedge clk);
    reg_idx_i = idx; #1;
    d = reg_rdata_o;
  endtask

  task automatic wait_status(input logic [31:0] mask, input logic [31:0] val, input string req);
    logic [31:0] s;
    for (int i = 0; i < 500; i++) begin
      rd(4'd0, s);
      if ((s & mask) == val) return;
    end
    check(req, s & mask, val);
  endtask

  task automatic t_reset;
    logic [31:0] s;
    rd(4'd0, s);
    check("R1 status", s, 32'h0);
    check("R1 irq", {31'h0, irq_o}, 32'h0);
    check("R1 req", {31'h0, mem_req_o}, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] s;
    for (int i = 1; i <= 8; i++) wr(4'(i), 32'hC000_0000 + 32'(i * 32'h0101_0104));
    for (int i = 1; i <= 8; i++) begin
      rd(4'(i), s);
      check("R3 readback", s, 32'hC000_0000 + 32'(i * 32'h0101_0104));
    end
    wr(4'd9, 32'h0000_0ABC);
    rd(4'd1, s);
    check("R11 alias to pointer", s, 32'h0000_0ABC);
    rd(4'd9, s);
    check("R11 alias read", s, 32'h0000_0ABC);
    rd(4'd0, s);
    check("R3 idle", s, 32'h0);
  endtask

  task automatic t_single_write;
    logic [31:0] s;
    wr(4'd0, 32'h18);
    wr(4'd1, 32'h40);
    wr(4'd2, 32'h50);
    n_wr = 0;
    wr(4'd0, 32'h41);  // set-write | set-enable
    wait_status(32'h1, 32'h0, "R7 shutdown");
    rd(4'd0, s);
    check("R7 status complete only", s, 32'h04);
    rd(4'd1, s);
    check("R7 pointer at end", s, 32'h50);
    check("R4 word count", 32'(n_wr), 32'd4);
    for (int a = 32'h40; a < 32'h50; a += 4)
      check("R5 write data", mem[a[9:2]], 32'hD0D0_0000 | 32'(a));
    repeat (5) @(negedge clk);
    check("R10 irq held", {31'h0, irq_o}, 32'h1);
    wr(4'd0, 32'h04);
    @(negedge clk);
    check("R10 irq cleared", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_chain_read;
    logic [31:0] s;
    wr(4'd0, 32'h18);
    wr(4'd1, 32'h80);
    wr(4'd2, 32'h88);
    wr(4'd3, 32'hA0);
    wr(4'd4, 32'h8000_00B0);
    n_push = 0;
    wr(4'd0, 32'h23);  // set-read | set-update | set-enable
    wait_status(32'h4, 32'h4, "R6 first boundary");
    rd(4'd0, s);
    check("R6 enable kept, pending cleared, read dir", s & 32'h13, 32'h11);
    rd(4'd6, s);
    check("R6 saved end", s, 32'h88);
    rd(4'd5, s);
    check("R6 saved pointer", s, 32'hA0);
    rd(4'd2, s);
    check("R8 end keeps bit31", s, 32'h8000_00B0);
    wait_status(32'h1, 32'h0, "R7 chained shutdown");
    rd(4'd1, s);
    check("R8 masked compare end", s, 32'hB0);
    rd(4'd6, s);
    check("R8 saved end keeps bit31", s, 32'h8000_00B0);
    check("R5 device pushes", 32'(n_push), 32'd6);
    check("R5 device data", last_push, 32'h5A00_00AC);
    wr(4'd0, 32'h04);
  endtask

  task automatic t_rearm;
    logic [31:0] s;
    wr(4'd0, 32'h18);
    wr(4'd1, 32'h100);
    wr(4'd2, 32'h104);
    wr(4'd3, 32'h110);
    wr(4'd4, 32'h130);
    wr(4'd0, 32'h43);  // set-write | set-update | set-enable
    wait_status(32'h4, 32'h4, "R10 first interrupt");
    wr(4'd3, 32'h120);
    wr(4'd4, 32'h124);
    wr(4'd0, 32'h46);  // clear-complete | set-write | set-update
    rd(4'd0, s);
    check("R10 rearm status", s & 32'h17, 32'h03);
    wait_status(32'h1, 32'h0, "R10 rearmed run ends");
    rd(4'd1, s);
    check("R10 second chain end", s, 32'h124);
    check("R10 second chain data", mem[8'h48], 32'hD0D0_0120);
    wr(4'd0, 32'h04);
  endtask

  task automatic t_error;
    logic [31:0] s;
    wr(4'd0, 32'h18);
    wr(4'd1, 32'h200);
    wr(4'd2, 32'h8000_0220);
    err_addr = 32'h208; err_en = 1'b1;
    wr(4'd0, 32'h41);
    wait_status(32'h1, 32'h0, "R9 stop on error");
    err_en = 1'b0;
    rd(4'd0, s);
    check("R9 status", s, 32'h0C);
    rd(4'd6, s);
    check("R9 saved end", s, 32'h8000_0208);
    rd(4'd1, s);
    check("R9 pointer not advanced", s, 32'h208);
    check("R9 irq", {31'h0, irq_o}, 32'h1);
    wr(4'd0, 32'h18);
    rd(4'd0, s);
    check("R2 reset command", s, 32'h0);
    check("R2 irq low", {31'h0, irq_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_regs();
    t_single_write();
    t_chain_read();
    t_rearm();
    t_error();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule